// File: doc/BRIEF.md
# Adder-Subtractor With Status Flags

This block is a parameterised two's-complement adder-subtractor that produces its result in the same cycle as its operands, together with six status indications: unsigned carry (borrow when subtracting), signed overflow, sign, zero, an auxiliary carry taken at the nibble boundary, and even parity. A select input chooses between addition and subtraction. A chaining input decides whether the carry input takes part, which gives the add-with-carry and subtract-with-borrow forms of each operation.

The flags are available straight from the combinational path. They are also captured into a six-bit flags register on a clock edge when the write enable is high, so a datapath can keep the condition of the last flag-setting operation while it runs other work. The adder itself has two forms, chosen by a parameter: an explicit ripple chain of full adders, or a single behavioural sum. Both forms produce the same carries into the nibble boundary and into the sign bit.

Top module: `addsub_flags`

## Requirements
- R1: `result_o` equals `opa_i + opb_i + k` modulo 2^WIDTH when `sub_i`=0, and `opa_i - opb_i - k` modulo 2^WIDTH when `sub_i`=1. Here k = `cin_i` when `chain_i`=1, and k = 0 otherwise.
- R2: `carry_o` is 1 when the add exceeds 2^WIDTH-1. When subtracting, it is 1 when `opa_i` is unsigned-less than `opb_i + k` (a borrow).
- R3: `ovf_o` is 1 on an add of two operands of equal sign whose result sign differs from them. It is 1 on a subtract of operands of different sign whose result sign differs from `opa_i`. It is 0 in every other case.
- R4: `sign_o` equals the most significant bit of `result_o`.
- R5: `zero_o` is 1 exactly when every bit of `result_o` is 0.
- R6: `aux_o` is the carry out of bit 3 into bit 4 when adding (low nibbles plus k exceed 15). When subtracting, it is the borrow out of the low nibble (low nibble of `opa_i` less than low nibble of `opb_i` plus k).
- R7: `parity_o` is 1 when the low 8 bits of `result_o` hold an even number of 1 bits.
- R8: `flags_q_o` is 0 while `rst_n` is low. On a rising clock edge with `flag_we_i`=1 it loads {ovf, sign, zero, aux, parity, carry}, with bit 5 = overflow, bit 4 = sign, bit 3 = zero, bit 2 = aux, bit 1 = parity and bit 0 = carry. With `flag_we_i`=0 it holds.
- R9: With `chain_i`=0 the value of `cin_i` has no effect on any output.
- R10: Carry and overflow are independent, and all four pairs occur. 15+8 gives neither, 255+1 gives carry only, 79+64 gives overflow only, and 218+157 gives both.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock for the flags register |
| rst_n | input | 1 | Active-low asynchronous reset |
| opa_i | input | WIDTH | First operand |
| opb_i | input | WIDTH | Second operand |
| sub_i | input | 1 | 0 = add, 1 = subtract |
| chain_i | input | 1 | 1 = include `cin_i` as carry or borrow in |
| cin_i | input | 1 | Carry in (add) or borrow in (subtract) |
| flag_we_i | input | 1 | Load enable for the flags register |
| result_o | output | WIDTH | Sum or difference |
| carry_o | output | 1 | Carry out or borrow out |
| ovf_o | output | 1 | Signed overflow |
| sign_o | output | 1 | Result is negative |
| zero_o | output | 1 | Result is zero |
| aux_o | output | 1 | Nibble carry or borrow |
| parity_o | output | 1 | Even parity of the low result byte |
| flags_q_o | output | 6 | Registered flags {ovf, sign, zero, aux, parity, carry} |

## Verification
The bench sweeps every operand pair for plain add and plain subtract, and adds a chained sweep with the carry input set. A design that takes the raw adder carry-out as the subtract flag would report a borrow exactly where none exists, and an inverted nibble carry would show up in the subtract aux flag. The chained sweep catches a carry input that is ignored, or used while chaining is off. The sweep also covers operand pairs of mixed sign, which expose an overflow rule copied from addition into subtraction. Directed sums hit each of the four carry/overflow pairs. A write enable that changes from vector to vector shows whether the flags register holds or loads on the right edge.

// File: rtl/addsub_flags_pkg.sv
package addsub_flags_pkg;
   typedef struct packed {
      logic ovf;
      logic sign;
      logic zero;
      logic aux;
      logic parity;
      logic carry;
   } flags_t;

   localparam int FLAG_COUNT = $bits(flags_t);
endpackage

// File: rtl/addsub_core.sv
module addsub_core #(
   parameter int WIDTH   = 8,
   parameter int AUX_BIT = 4,
   parameter bit RIPPLE  = 1'b1
) (
   input  logic [WIDTH-1:0] opa,
   input  logic [WIDTH-1:0] opb,
   input  logic             sub,
   input  logic             k_in,
   output logic [WIDTH-1:0] sum,
   output logic             c_out,
   output logic             c_aux,
   output logic             c_msb
);
   localparam int MSB = WIDTH - 1;

   logic [WIDTH-1:0] b_eff;
   logic             c0;

   // subtraction is a + ~b + 1 - borrow
   assign b_eff = sub ? ~opb : opb;
   assign c0    = sub ? ~k_in : k_in;

   if (RIPPLE) begin : g_ripple
      logic [WIDTH:0] chain;
      assign chain[0] = c0;
      for (genvar i = 0; i < WIDTH; i++) begin : g_bit
         assign sum[i]     = opa[i] ^ b_eff[i] ^ chain[i];
         assign chain[i+1] = (opa[i] & b_eff[i]) | (chain[i] & (opa[i] ^ b_eff[i]));
      end
      assign c_out = chain[WIDTH];
      assign c_aux = chain[AUX_BIT];
      assign c_msb = chain[MSB];
   end else begin : g_behav
      logic [WIDTH:0] full;
      assign full  = {1'b0, opa} + {1'b0, b_eff} + {{WIDTH{1'b0}}, c0};
      assign sum   = full[MSB:0];
      assign c_out = full[WIDTH];
      // carry into bit j is recovered from the sum bit and both addend bits
      assign c_aux = full[AUX_BIT] ^ opa[AUX_BIT] ^ b_eff[AUX_BIT];
      assign c_msb = full[MSB] ^ opa[MSB] ^ b_eff[MSB];
   end
endmodule

// File: rtl/flag_gen.sv
module flag_gen
   import addsub_flags_pkg::*;
#(
   parameter int WIDTH    = 8,
   parameter int PAR_BITS = 8
) (
   input  logic [WIDTH-1:0] sum,
   input  logic             sub,
   input  logic             c_out,
   input  logic             c_aux,
   input  logic             c_msb,
   output flags_t           flags
);
   always_comb begin
      flags.carry  = c_out ^ sub;        // borrow is the inverted carry
      flags.aux    = c_aux ^ sub;
      flags.ovf    = c_msb ^ c_out;
      flags.sign   = sum[WIDTH-1];
      flags.zero   = ~|sum;
      flags.parity = ~^sum[PAR_BITS-1:0];
   end

   // a zero result has no set bits, so it must read as even parity and non-negative
   always_comb begin
      if (flags.zero) begin
         p_zero_even_r7 : assert (flags.parity);
         p_zero_positive_r5 : assert (!flags.sign);
      end
   end
endmodule

// File: rtl/flag_reg.sv
module flag_reg #(
   parameter int BITS = 6
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            we,
   input  logic [BITS-1:0] d,
   output logic [BITS-1:0] q
);
   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n)  q <= '0;
      else if (we) q <= d;
   end

   p_hold_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      !we |=> $stable(q));
   p_load_r8 : assert property (@(posedge clk) disable iff (!rst_n)
      we |=> (q == $past(d)));
endmodule

// File: rtl/addsub_flags.sv
module addsub_flags
   import addsub_flags_pkg::*;
#(
   parameter int WIDTH    = 8,
   parameter int AUX_BIT  = 4,
   parameter int PAR_BITS = 8,
   parameter bit RIPPLE   = 1'b1
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic [WIDTH-1:0] opa_i,
   input  logic [WIDTH-1:0] opb_i,
   input  logic             sub_i,
   input  logic             chain_i,
   input  logic             cin_i,
   input  logic             flag_we_i,
   output logic [WIDTH-1:0] result_o,
   output logic             carry_o,
   output logic             ovf_o,
   output logic             sign_o,
   output logic             zero_o,
   output logic             aux_o,
   output logic             parity_o,
   output logic [5:0]       flags_q_o
);
   localparam int MSB = WIDTH - 1;

   if (WIDTH < 2) begin : g_chk_width
      $error("addsub_flags: WIDTH must be at least 2");
   end
   if (AUX_BIT < 1 || AUX_BIT >= WIDTH) begin : g_chk_aux
      $error("addsub_flags: AUX_BIT must lie inside the word");
   end
   if (PAR_BITS < 1 || PAR_BITS > WIDTH) begin : g_chk_par
      $error("addsub_flags: PAR_BITS must not exceed WIDTH");
   end
   if (FLAG_COUNT != 6) begin : g_chk_flags
      $error("addsub_flags: flag record must be six bits");
   end

   logic   k_eff;
   logic   c_out, c_aux, c_msb;
   flags_t flags;

   assign k_eff = chain_i & cin_i;

   addsub_core #(.WIDTH(WIDTH), .AUX_BIT(AUX_BIT), .RIPPLE(RIPPLE)) u_core (
      .opa(opa_i), .opb(opb_i), .sub(sub_i), .k_in(k_eff),
      .sum(result_o), .c_out(c_out), .c_aux(c_aux), .c_msb(c_msb)
   );

   flag_gen #(.WIDTH(WIDTH), .PAR_BITS(PAR_BITS)) u_flags (
      .sum(result_o), .sub(sub_i), .c_out(c_out), .c_aux(c_aux), .c_msb(c_msb),
      .flags(flags)
   );

   flag_reg #(.BITS(6)) u_freg (
      .clk(clk), .rst_n(rst_n), .we(flag_we_i), .d(flags), .q(flags_q_o)
   );

   assign carry_o  = flags.carry;
   assign ovf_o    = flags.ovf;
   assign sign_o   = flags.sign;
   assign zero_o   = flags.zero;
   assign aux_o    = flags.aux;
   assign parity_o = flags.parity;

   // mixed-sign add and same-sign subtract can never leave the signed range
   p_add_mixed_ovf_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (!sub_i && (opa_i[MSB] != opb_i[MSB])) |-> !ovf_o);
   p_sub_same_ovf_r3 : assert property (@(posedge clk) disable iff (!rst_n)
      (sub_i && (opa_i[MSB] == opb_i[MSB])) |-> !ovf_o);
   // no borrow when the minuend is not below the subtrahend and no borrow-in
   p_sub_no_borrow_r2 : assert property (@(posedge clk) disable iff (!rst_n)
      (sub_i && !k_eff && (opa_i >= opb_i)) |-> !carry_o);
   // adding zero with no carry in reproduces the operand
   p_add_zero_r1 : assert property (@(posedge clk) disable iff (!rst_n)
      (!sub_i && !k_eff && (opb_i == '0)) |-> (result_o == opa_i) && !carry_o);
   p_reset_clear_r8 : assert property (@(posedge clk)
      !rst_n |-> (flags_q_o == 6'd0));
endmodule

// File: tb/addsub_flags_test.sv
`timescale 1ns/1ps
module addsub_flags_test;
   logic       clk = 1'b0;
   logic       rst_n = 1'b0;
   logic [7:0] opa = '0, opb = '0;
   logic       sub = 1'b0, chain = 1'b0, cin = 1'b0, we = 1'b0;
   logic [7:0] result;
   logic       carry, ovf, sign, zero, aux, parity;
   logic [5:0] flags_q;

   int vectors = 0;
   int errors  = 0;
   bit done    = 1'b0;
   logic [5:0] exp_q = '0;

   always #2 clk = ~clk;   // 250 MHz

   addsub_flags uut (
      .clk(clk), .rst_n(rst_n), .opa_i(opa), .opb_i(opb), .sub_i(sub),
      .chain_i(chain), .cin_i(cin), .flag_we_i(we), .result_o(result),
      .carry_o(carry), .ovf_o(ovf), .sign_o(sign), .zero_o(zero),
      .aux_o(aux), .parity_o(parity), .flags_q_o(flags_q)
   );

   task automatic fail_bit(string tag, string what, int act, int exp);
      errors++;
      $display("FAIL %s %s: a=%0d b=%0d sub=%0d chain=%0d cin=%0d actual=%0d expected=%0d",
               tag, what, opa, opb, sub, chain, cin, act, exp);
   endtask

   // drive one vector at the falling edge, compare, then let the register edge pass
   task automatic apply(input int a, input int b, input bit s, input bit ch,
                        input bit ci, input bit w);
      int k, full, nib, r;
      bit e_c, e_v, e_n, e_z, e_a, e_p;
      logic [5:0] nxt;
      @(negedge clk);
      opa = a[7:0]; opb = b[7:0]; sub = s; chain = ch; cin = ci; we = w;
      #1;
      k = ch ? int'(ci) : 0;   // R9: carry in is dropped when chaining is off
      if (!s) begin
         full = a + b + k;  nib = (a % 16) + (b % 16) + k;
         e_c = full > 255;  e_a = nib > 15;
      end else begin
         full = a - b - k;  nib = (a % 16) - (b % 16) - k;
         e_c = full < 0;    e_a = nib < 0;
      end
      r   = full & 255;
      e_n = r >= 128;
      e_z = r == 0;
      e_p = ($countones(r[7:0]) % 2) == 0;
      if (!s) e_v = ((a >= 128) == (b >= 128)) && ((a >= 128) != e_n);
      else    e_v = ((a >= 128) != (b >= 128)) && ((a >= 128) != e_n);
      vectors++;
      if (int'(result) != r)   fail_bit("R1/R9", "result", int'(result), r);
      if (carry  != e_c)       fail_bit("R2", "carry", carry, e_c);
      if (ovf    != e_v)       fail_bit("R3", "overflow", ovf, e_v);
      if (sign   != e_n)       fail_bit("R4", "sign", sign, e_n);
      if (zero   != e_z)       fail_bit("R5", "zero", zero, e_z);
      if (aux    != e_a)       fail_bit("R6", "aux", aux, e_a);
      if (parity != e_p)       fail_bit("R7", "parity", parity, e_p);
      if (flags_q != exp_q)    fail_bit("R8", "flags_q", flags_q, exp_q);
      nxt = w ? {e_v, e_n, e_z, e_a, e_p, e_c} : exp_q;
      @(posedge clk);
      exp_q = nxt;
   endtask

   task automatic check_cv(string tag, bit ec, bit ev);
      vectors++;
      if (carry != ec) fail_bit(tag, "carry pair", carry, ec);
      if (ovf   != ev) fail_bit(tag, "overflow pair", ovf, ev);
   endtask

   initial begin
      repeat (3) @(negedge clk);
      vectors++;
      if (flags_q != 6'd0) fail_bit("R8", "reset flags", flags_q, 0);
      @(negedge clk);
      rst_n = 1'b1;

      // R10: each carry/overflow pair, checked before the next vector is driven
      apply(15, 8, 0, 0, 0, 1);     check_cv("R10", 0, 0);
      apply(255, 1, 0, 0, 0, 1);    check_cv("R10", 1, 0);
      apply(79, 64, 0, 0, 0, 1);    check_cv("R10", 0, 1);
      apply(218, 157, 0, 0, 0, 1);  check_cv("R10", 1, 1);

      // R8: hold with enable low for several edges
      apply(0, 0, 0, 0, 0, 0);
      apply(128, 128, 1, 0, 0, 0);

      // R1..R7 exhaustive plain add and subtract, enable toggling for R8
      for (int s = 0; s < 2; s++)
         for (int a = 0; a < 256; a++)
            for (int b = 0; b < 256; b++)
               apply(a, b, s[0], 0, 1'(b % 3 == 0), 1'((a ^ b) & 1));

      // R9 and chained forms: carry in set, chaining on and off
      for (int s = 0; s < 2; s++)
         for (int ch = 0; ch < 2; ch++)
            for (int a = 0; a < 256; a++)
               for (int j = 0; j < 16; j++)
                  apply(a, (a * 37 + j * 17 + 11) % 256, s[0], ch[0], 1, 1'(j & 1));

      if (!done) begin
         done = 1'b1;
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end

   initial begin
      repeat (195000) @(posedge clk);
      if (!done) begin
         done = 1'b1;
         errors++;
         $display("FAIL watchdog: run did not complete, actual=timeout expected=finish");
         $display("== %0d vectors applied, %0d miscompares ==", vectors, errors);
         $finish;
      end
   end
endmodule